// File: doc/BRIEF.md
# Frame-Synchronized DMA Settings Commit

This block holds the settings of a display DMA controller in two copies. Software writes always land in a shadow copy. A second, active copy drives the DMA. The shadow holds the DMA enable, the framebuffer base address, the line stride and a 2-bit load-point option. The active copy changes only at a frame-boundary event during vertical blanking, and only while software has armed a commit through a load-request bit. The hardware clears that bit in the same cycle it copies the shadow values into the active copy.

An external video timing generator supplies three single-cycle events. The first is data enable falling after the last active line, which is the start of the front porch. The second is the start of the vsync pulse. The third is the start of the back porch. The load-point option picks one of them. At each selected event the block pulses a FIFO-clear output. It also pulses a fetch-start output when the resulting active enable is set.

Software that wants to be sure a disable has taken effect polls the load-request bit until it reads zero. This can take up to one frame, because the frame being fetched finishes first.

Top module: `dma_shadow_commit`

## Requirements
- R1: While `rst_n` is low at a clock edge, all shadow and active settings, the load request, `fifo_clr` and `fetch_start` become 0, and a read of any register returns 0.
- R2: A register write changes only the shadow copy. `act_en`, `act_base` and `act_stride` keep their values unless a commit happens, including across load points with no request pending.
- R3: Reading the control register (address 0) returns the shadow enable in bit 0 as soon as the write is done, so clearing it reads 0 at once. Bit 16 returns the active enable, which is read-only.
- R4: Writing 1 to control bit 15 arms a commit. At the edge where the selected load point is high and the request is armed, all active settings take the shadow values, and bit 15 reads 0 after that edge.
- R5: Control bits 9:8 pick the load point. 00 selects `ev_de_fall`, 01 selects `ev_vsync`, 10 selects `ev_bporch`, and 11 acts as 00. Events that are not selected cause no commit and no pulse.
- R6: `fifo_clr` is high for exactly the one cycle after each edge where the selected load point is high, whether or not a commit happens.
- R7: `fetch_start` pulses in the same cycle as `fifo_clr`, but only when the active enable after that edge is 1.
- R8: A write in the commit cycle goes into the shadow copy but not into the active copy. If that write sets control bit 15, the request stays armed for the next load point.
- R9: An armed request whose load point has already passed in the current blanking stays pending across idle cycles and other events until the next selected load point.
- R10: Register addresses are: 1 for the base address, 2 for the stride, 0 for control. Writes to other addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (2) | Write address |
| wr_data | input | DW (32) | Write data |
| rd_addr | input | AW (2) | Read address |
| rd_data | output | DW (32) | Read data, combinational from `rd_addr` |
| ev_de_fall | input | 1 | Pulse: data enable fell after the last active line |
| ev_vsync | input | 1 | Pulse: vsync begins |
| ev_bporch | input | 1 | Pulse: vertical back porch begins |
| act_en | output | 1 | Active DMA enable |
| act_base | output | BASE_W (32) | Active framebuffer base address |
| act_stride | output | STRIDE_W (16) | Active line stride |
| fifo_clr | output | 1 | One-cycle pixel FIFO clear pulse |
| fetch_start | output | 1 | One-cycle frame fetch start pulse |

## Verification
Every result comes from one register stage. The active settings, the two pulses and the cleared load bit appear right after the edge that samples the event and the armed request. A shadow write shows on `rd_data` right after its own edge, with no wait for an event. The bench drives inputs on the falling edge and applies one rising edge. It then compares outputs and read data on the next falling edge, before it changes any input, so each pulse is seen in the one cycle it is high. The commit-cycle cases put the write and the event on the same edge and compare the shadow readback with the active ports at that single sample point.

// File: rtl/shc_pkg.sv
// Package: shared constants and types of the shadow commit bank.
// Assumes a 32-bit-or-wider register data path so control bit 16 exists.
package shc_pkg;
    // Register addresses
    localparam int REG_CTRL   = 0;
    localparam int REG_BASE   = 1;
    localparam int REG_STRIDE = 2;

    // Control register bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_OPT_LSB  = 8;
    localparam int CTRL_LOAD_BIT = 15;
    localparam int CTRL_ACT_BIT  = 16;

    // Load point selection codes
    typedef enum logic [1:0] {
        LP_DE_FALL = 2'b00,
        LP_VSYNC   = 2'b01,
        LP_BPORCH  = 2'b10,
        LP_RSVD    = 2'b11
    } lp_sel_e;
endpackage

// File: rtl/shc_regfile.sv
// Module: shadow register file with the self-clearing load request.
// Holds the software-visible shadow settings and serves reads.
// Assumes commit is a single-cycle strobe from the active stage.
module shc_regfile
    import shc_pkg::*;
#(
    parameter int AW       = 2,
    parameter int DW       = 32,
    parameter int BASE_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data,
    input  logic                commit,
    input  logic                act_en,
    output logic                sh_en,
    output lp_sel_e             sh_opt,
    output logic [BASE_W-1:0]   sh_base,
    output logic [STRIDE_W-1:0] sh_stride,
    output logic                load_req
);
    logic wr_ctrl;
    assign wr_ctrl = wr_en && (wr_addr == AW'(REG_CTRL));

    // Capture software writes into the shadow copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_en     <= 1'b0;
            sh_opt    <= LP_DE_FALL;
            sh_base   <= '0;
            sh_stride <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(REG_CTRL)) begin
                sh_en  <= wr_data[CTRL_EN_BIT];
                sh_opt <= lp_sel_e'(wr_data[CTRL_OPT_LSB +: 2]);
            end
            if (wr_addr == AW'(REG_BASE))
                sh_base <= wr_data[BASE_W-1:0];
            if (wr_addr == AW'(REG_STRIDE))
                sh_stride <= wr_data[STRIDE_W-1:0];
        end
    end

    // Load request: set by software, cleared by a commit, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_req <= 1'b0;
        else if (wr_ctrl && wr_data[CTRL_LOAD_BIT])
            load_req <= 1'b1;
        else if (commit)
            load_req <= 1'b0;
    end

    // Read multiplexer over the shadow copy plus active enable status
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(REG_CTRL)) begin
            rd_data[CTRL_EN_BIT]           = sh_en;
            rd_data[CTRL_OPT_LSB +: 2]     = sh_opt;
            rd_data[CTRL_LOAD_BIT]         = load_req;
            rd_data[CTRL_ACT_BIT]          = act_en;
        end else if (rd_addr == AW'(REG_BASE)) begin
            rd_data = DW'(sh_base);
        end else if (rd_addr == AW'(REG_STRIDE)) begin
            rd_data = DW'(sh_stride);
        end
    end
endmodule

// File: rtl/shc_event_sel.sv
// Module: picks the frame-boundary load point from the timing events.
// Assumes each event is a single-cycle pulse from the timing generator.
module shc_event_sel
    import shc_pkg::*;
(
    input  lp_sel_e sel,
    input  logic    ev_de_fall,
    input  logic    ev_vsync,
    input  logic    ev_bporch,
    output logic    load_pt
);
    // Route the chosen event; the reserved code falls back to front porch
    always_comb begin
        unique case (sel)
            LP_VSYNC:  load_pt = ev_vsync;
            LP_BPORCH: load_pt = ev_bporch;
            default:   load_pt = ev_de_fall;
        endcase
    end
endmodule

// File: rtl/shc_active.sv
// Module: active settings and the per-frame pulses.
// Copies the shadow values when the load point meets an armed request.
// Assumes load_pt is a one-cycle strobe.
module shc_active #(
    parameter int BASE_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_pt,
    input  logic                load_req,
    input  logic                sh_en,
    input  logic [BASE_W-1:0]   sh_base,
    input  logic [STRIDE_W-1:0] sh_stride,
    output logic                commit,
    output logic                act_en,
    output logic [BASE_W-1:0]   act_base,
    output logic [STRIDE_W-1:0] act_stride,
    output logic                fifo_clr,
    output logic                fetch_start
);
    logic next_en;
    assign commit  = load_pt && load_req;
    assign next_en = commit ? sh_en : act_en;

    // Transfer shadow to active on a commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en     <= 1'b0;
            act_base   <= '0;
            act_stride <= '0;
        end else if (commit) begin
            act_en     <= sh_en;
            act_base   <= sh_base;
            act_stride <= sh_stride;
        end
    end

    // Issue the FIFO clear and fetch start pulses at each load point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_clr    <= 1'b0;
            fetch_start <= 1'b0;
        end else begin
            fifo_clr    <= load_pt;
            fetch_start <= load_pt && next_en;
        end
    end
endmodule

// File: rtl/dma_shadow_commit.sv
// Module: top of the frame-synchronized DMA settings bank.
// Wires the shadow register file, the load point selector and the
// active stage. Assumes timing events are synchronous to clk.
module dma_shadow_commit
    import shc_pkg::*;
#(
    parameter int AW       = 2,
    parameter int DW       = 32,
    parameter int BASE_W   = 32,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data,
    input  logic                ev_de_fall,
    input  logic                ev_vsync,
    input  logic                ev_bporch,
    output logic                act_en,
    output logic [BASE_W-1:0]   act_base,
    output logic [STRIDE_W-1:0] act_stride,
    output logic                fifo_clr,
    output logic                fetch_start
);
    logic                sh_en;
    lp_sel_e             sh_opt;
    logic [BASE_W-1:0]   sh_base;
    logic [STRIDE_W-1:0] sh_stride;
    logic                load_req;
    logic                load_pt;
    logic                commit;

    shc_regfile #(
        .AW(AW), .DW(DW), .BASE_W(BASE_W), .STRIDE_W(STRIDE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .commit(commit), .act_en(act_en),
        .sh_en(sh_en), .sh_opt(sh_opt), .sh_base(sh_base),
        .sh_stride(sh_stride), .load_req(load_req)
    );

    shc_event_sel u_sel (
        .sel(sh_opt), .ev_de_fall(ev_de_fall), .ev_vsync(ev_vsync),
        .ev_bporch(ev_bporch), .load_pt(load_pt)
    );

    shc_active #(
        .BASE_W(BASE_W), .STRIDE_W(STRIDE_W)
    ) u_act (
        .clk(clk), .rst_n(rst_n),
        .load_pt(load_pt), .load_req(load_req),
        .sh_en(sh_en), .sh_base(sh_base), .sh_stride(sh_stride),
        .commit(commit), .act_en(act_en), .act_base(act_base),
        .act_stride(act_stride), .fifo_clr(fifo_clr),
        .fetch_start(fetch_start)
    );
endmodule

// File: rtl/shc_checker.sv
// Checker: temporal properties of the shadow commit bank, bound to the top.
module shc_checker #(
    parameter int AW       = 2,
    parameter int DW       = 32,
    parameter int BASE_W   = 32,
    parameter int STRIDE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [AW-1:0]       wr_addr,
    input logic [DW-1:0]       wr_data,
    input logic                load_pt,
    input logic                load_req,
    input logic                ev_de_fall,
    input logic                ev_vsync,
    input logic [1:0]          sh_opt,
    input logic                act_en,
    input logic [BASE_W-1:0]   act_base,
    input logic [STRIDE_W-1:0] act_stride,
    input logic                fifo_clr,
    input logic                fetch_start
);
    logic rearm;
    assign rearm = wr_en && (wr_addr == AW'(0)) && wr_data[15];

    // R2: active settings move only on a commit
    a_r2_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_pt && load_req) |=> ($stable(act_en) && $stable(act_base) && $stable(act_stride)));

    // R4: a commit clears the request unless software re-arms it
    a_r4_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pt && load_req && !rearm) |=> !load_req);

    // R8: a re-arming write in the commit cycle keeps the request
    a_r8_rearm_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> load_req);

    // R6: FIFO clear follows each load point and nothing else
    a_r6_fifo_follows: assert property (@(posedge clk) disable iff (!rst_n)
        load_pt |=> fifo_clr);
    a_r6_fifo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pt |=> !fifo_clr);

    // R7: fetch start only with an enabled DMA and a FIFO clear
    a_r7_fetch_gated: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_start |-> (act_en && fifo_clr));

    // R5: reserved code ignores vsync
    a_r5_rsvd_ignores_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_opt == 2'b11 && ev_vsync && !ev_de_fall) |-> !load_pt);
endmodule

bind dma_shadow_commit shc_checker #(
    .AW(AW), .DW(DW), .BASE_W(BASE_W), .STRIDE_W(STRIDE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_pt(load_pt), .load_req(load_req),
    .ev_de_fall(ev_de_fall), .ev_vsync(ev_vsync), .sh_opt(sh_opt),
    .act_en(act_en), .act_base(act_base), .act_stride(act_stride),
    .fifo_clr(fifo_clr), .fetch_start(fetch_start)
);

// File: tb/sim_dma_shadow_commit.sv
module sim_dma_shadow_commit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        ev_de_fall, ev_vsync, ev_bporch;
    logic        act_en;
    logic [31:0] act_base;
    logic [15:0] act_stride;
    logic        fifo_clr, fetch_start;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dma_shadow_commit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_de_fall(ev_de_fall), .ev_vsync(ev_vsync), .ev_bporch(ev_bporch),
        .act_en(act_en), .act_base(act_base), .act_stride(act_stride),
        .fifo_clr(fifo_clr), .fetch_start(fetch_start)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  addr;
        logic [31:0] wd;
        logic [2:0]  ev;   // bit0 de_fall, bit1 vsync, bit2 back porch
        logic        x_en;
        logic [31:0] x_base;
        logic        x_fc;
        logic        x_fs;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd1, 32'h0000_1000, 3'b000, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R2 write base only
        '{1'b1, 2'd0, 32'h0000_8001, 3'b000, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R4 arm, en=1 opt 00
        '{1'b0, 2'd0, 32'h0000_0000, 3'b010, 1'b0, 32'h0000_0000, 1'b0, 1'b0}, // R5 vsync not selected
        '{1'b0, 2'd0, 32'h0000_0000, 3'b001, 1'b1, 32'h0000_1000, 1'b1, 1'b1}, // R4 R7 commit at de_fall
        '{1'b0, 2'd0, 32'h0000_0000, 3'b000, 1'b1, 32'h0000_1000, 1'b0, 1'b0}, // R6 pulse lasts one cycle
        '{1'b1, 2'd1, 32'h0000_2000, 3'b001, 1'b1, 32'h0000_1000, 1'b1, 1'b1}, // R2 R6 no request pending
        '{1'b1, 2'd0, 32'h0000_8100, 3'b000, 1'b1, 32'h0000_1000, 1'b0, 1'b0}, // R5 arm disable, opt 01
        '{1'b0, 2'd0, 32'h0000_0000, 3'b001, 1'b1, 32'h0000_1000, 1'b0, 1'b0}, // R5 de_fall not selected
        '{1'b0, 2'd0, 32'h0000_0000, 3'b010, 1'b0, 32'h0000_2000, 1'b1, 1'b0}, // R7 commit disable at vsync
        '{1'b0, 2'd0, 32'h0000_0000, 3'b010, 1'b0, 32'h0000_2000, 1'b1, 1'b0}  // R6 pulse with no commit
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        ev_de_fall = 1'b0; ev_vsync = 1'b0; ev_bporch = 1'b0;
    endtask

    // One cycle: current inputs applied at a rising edge, then inputs cleared
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic out_chk(input string tag, input logic en, input logic fc, input logic fs);
        chk({tag, " act_en"}, 32'(act_en), 32'(en));
        chk({tag, " fifo_clr"}, 32'(fifo_clr), 32'(fc));
        chk({tag, " fetch_start"}, 32'(fetch_start), 32'(fs));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rd_addr = '0;
        idle();
        repeat (3) @(negedge clk);
        // R1 reset state
        out_chk("R1 reset", 1'b0, 1'b0, 1'b0);
        chk("R1 base", act_base, 32'h0);
        rd_chk("R1 ctrl read", 2'd0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i].we; wr_addr = VEC[i].addr; wr_data = VEC[i].wd;
            ev_de_fall = VEC[i].ev[0]; ev_vsync = VEC[i].ev[1]; ev_bporch = VEC[i].ev[2];
            tick();
            out_chk($sformatf("R2/R4/R5/R6/R7 vec %0d", i), VEC[i].x_en, VEC[i].x_fc, VEC[i].x_fs);
            chk($sformatf("R2/R4 vec %0d base", i), act_base, VEC[i].x_base);
        end

        // R3 shadow readback immediately, status shows active
        wr(2'd0, 32'h0000_0001);
        rd_chk("R3 shadow en read", 2'd0, 32'h0000_0001);
        chk("R3 active unchanged", 32'(act_en), 32'h0);
        wr(2'd0, 32'h0000_8001);
        ev_de_fall = 1'b1; tick();
        wr(2'd0, 32'h0000_0000);
        rd_chk("R3 cleared en reads 0, status 1", 2'd0, 32'h0001_0000);
        chk("R3 DMA still active", 32'(act_en), 32'h1);

        // R5 option 10 selects back porch
        wr(2'd0, 32'h0000_8200);
        ev_vsync = 1'b1; tick();
        out_chk("R5 opt10 vsync ignored", 1'b1, 1'b0, 1'b0);
        ev_de_fall = 1'b1; tick();
        out_chk("R5 opt10 de_fall ignored", 1'b1, 1'b0, 1'b0);
        ev_bporch = 1'b1; tick();
        out_chk("R5 opt10 back porch commit", 1'b0, 1'b1, 1'b0);

        // R5 option 11 behaves as 00
        wr(2'd0, 32'h0000_8301);
        ev_bporch = 1'b1; tick();
        out_chk("R5 opt11 back porch ignored", 1'b0, 1'b0, 1'b0);
        ev_de_fall = 1'b1; tick();
        out_chk("R5 opt11 de_fall commit", 1'b1, 1'b1, 1'b1);

        // R8 write in commit cycle goes to shadow only
        wr(2'd2, 32'h0000_0040);
        wr(2'd0, 32'h0000_8001);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h0000_0080; ev_de_fall = 1'b1;
        tick();
        chk("R8 active stride old", 32'(act_stride), 32'h40);
        rd_chk("R8 shadow stride new", 2'd2, 32'h0000_0080);
        rd_chk("R4 load bit cleared", 2'd0, 32'h0001_0001);

        // R8 re-arming control write in commit cycle
        wr(2'd0, 32'h0000_8001);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h0000_8000; ev_de_fall = 1'b1;
        tick();
        chk("R8 active en old value", 32'(act_en), 32'h1);
        rd_chk("R8 request re-armed", 2'd0, 32'h0001_8000);
        ev_de_fall = 1'b1; tick();
        out_chk("R8 next load point commits", 1'b0, 1'b1, 1'b0);
        chk("R8 stride moved", 32'(act_stride), 32'h80);

        // R9 late request waits for the next selected load point
        wr(2'd0, 32'h0000_8001);
        repeat (5) tick();
        ev_vsync = 1'b1; tick();
        ev_bporch = 1'b1; tick();
        chk("R9 still pending en", 32'(act_en), 32'h0);
        rd_chk("R9 still pending bit", 2'd0, 32'h0000_8001);
        ev_de_fall = 1'b1; tick();
        out_chk("R9 commit next frame", 1'b1, 1'b1, 1'b1);

        // R10 unmapped address write is ignored
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk("R10 ctrl untouched", 2'd0, 32'h0001_0001);
        rd_chk("R10 stride untouched", 2'd2, 32'h0000_0080);
        rd_chk("R10 unmapped reads 0", 2'd3, 32'h0);

        // R1 reset mid-run
        rst_n = 1'b0; tick();
        out_chk("R1 reset again", 1'b0, 1'b0, 1'b0);
        chk("R1 stride zero", 32'(act_stride), 32'h0);
        rd_chk("R1 base read zero", 2'd1, 32'h0);
        rst_n = 1'b1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule